// File: doc/BRIEF.md
# Passive Sensor Sequencer with Sigma-Delta Conversion

This block shares a single passive sensor line between two jobs in a fixed repeating frame. First it drives a power-enable output so the external transistors feed the sensor. Next it drops power and waits a settle window, so the external RC integrator can reach its reference level. Last it runs a first-order sigma-delta loop for a fixed integrate window, and counts how often the comparator reads 1. The count is the raw reading. The frame then starts again.

The loop is closed outside the chip. The comparator input is synchronised by two flops. On each sample tick the feedback output takes the inverse of the synchronised comparator bit, and on ticks inside the integrate window a 1 adds to the count. A sample tick falls every `DIV = INTEG_CYC / 2**RES_W` clocks, so the integrate window holds exactly `2**RES_W` ticks; the window length must be a whole multiple of `2**RES_W` clocks. At the end of the window the raw result and a 0..100 scaled reading are registered together and flagged by a one-cycle strobe. With defaults (250 cycles per microsecond; 1536 us, 256 us and 256 us windows) a frame lasts exactly 2048 us. The shorted-input reading sits near 130 and the open-input reading near 447.

Top module: `sensor_sd_sequencer`

## Requirements
- R1: `sensor_pwr_en` is 1 for exactly POWER_CYC consecutive cycles at the start of each frame and 0 for the rest of it; a frame is POWER_CYC+SETTLE_CYC+INTEG_CYC cycles, with the first frame starting in the first cycle after reset is released.
- R2: `sd_fb` is 0 whenever `sensor_pwr_en` is 1; in the settle and integrate windows it takes, on each sample tick, the inverse of the comparator input delayed by the two-flop synchroniser, so a comparator held at 0 gives `sd_fb`=1 and one held at 1 gives `sd_fb`=0 by the end of the settle window.
- R3: Comparator ones seen during the power and settle windows are not counted, and the count restarts at zero at the start of each integrate window, so a frame with ones only there yields 0 even after a frame of all ones.
- R4: `raw_value` equals the number of sample ticks in the integrate window on which the synchronised comparator bit was 1, saturated at 2**RES_W-1 (511 by default); all zeros give 0 and all ones give 511.
- R5: `value_valid` is a single-cycle pulse, once per frame, in the first cycle after the integrate window (one frame apart); `raw_value` and `scaled_value` change only in a cycle where `value_valid` is 1.
- R6: `scaled_value` is 0 when raw is below 130, otherwise min(100, ((raw-130)*81)>>8) as an unsigned 7-bit value.
- R7: During and right after reset, `sensor_pwr_en`=1, `sd_fb`=0, `value_valid`=0, `raw_value`=0 and `scaled_value`=0.
- R8: With the external first-order loop closed, `raw_value` tracks the input level: an input of X/512 of full scale reads within a few counts of X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_cmp | input | 1 | Comparator output from the external integrator, asynchronous |
| sensor_pwr_en | output | 1 | Sensor power enable, high during the power window |
| sd_fb | output | 1 | Sigma-delta feedback to the external integrator |
| raw_value | output | RES_W | Raw conversion result |
| scaled_value | output | 7 | Result scaled to 0..100 |
| value_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that the comparator input settles at some level between edges, that the integrate window is a whole multiple of `2**RES_W` clocks, and that reset is held until the first frame starts. The stimulus drives the comparator only on falling clock edges. It uses three patterns: a constant level, a level that drops in the middle of the settle window, and a behavioural integrator. The integrator reacts to `sd_fb` and is clamped, so that it recovers inside the settle window. This exercises exact counts at both ends of the range as well as realistic mid-range readings.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    PH_POWER  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_INTEG  = 2'd2
  } phase_e;

  localparam int SC_OFFSET = 130;
  localparam int SC_GAIN   = 81;
  localparam int SC_SHIFT  = 8;
  localparam int SC_LIMIT  = 100;

  // Offset, multiply, shift and clamp a raw reading to 0..100.
  function automatic logic [6:0] scale_reading(input logic [15:0] raw);
    logic [15:0] diff;
    logic [22:0] prod;
    logic [14:0] shifted;
    if (raw < 16'(SC_OFFSET)) return 7'd0;
    diff    = raw - 16'(SC_OFFSET);
    prod    = 23'(diff) * 23'(SC_GAIN);
    shifted = 15'(prod >> SC_SHIFT);
    if (shifted > 15'(SC_LIMIT)) return 7'(SC_LIMIT);
    return shifted[6:0];
  endfunction

endpackage

// File: rtl/sdseq_timer.sv
module sdseq_timer
  import sdseq_pkg::*;
#(
  parameter int POWER_CYC  = 384000,
  parameter int SETTLE_CYC = 64000,
  parameter int INTEG_CYC  = 64000
) (
  input  logic   clk,
  input  logic   rst,
  output phase_e phase,
  output logic   last_cyc
);
  localparam int MAX_PS  = (POWER_CYC > SETTLE_CYC) ? POWER_CYC : SETTLE_CYC;
  localparam int MAX_LEN = (MAX_PS > INTEG_CYC) ? MAX_PS : INTEG_CYC;
  localparam int CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_m1;
  phase_e        phase_q;

  always_comb begin
    case (phase_q)
      PH_POWER:  len_m1 = CW'(POWER_CYC - 1);
      PH_SETTLE: len_m1 = CW'(SETTLE_CYC - 1);
      default:   len_m1 = CW'(INTEG_CYC - 1);
    endcase
  end

  assign last_cyc = (cnt_q == len_m1);
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= PH_POWER;
    end else if (last_cyc) begin
      cnt_q <= '0;
      case (phase_q)
        PH_POWER:  phase_q <= PH_SETTLE;
        PH_SETTLE: phase_q <= PH_INTEG;
        default:   phase_q <= PH_POWER;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: windows follow power -> settle -> integrate -> power, never skipping
  a_r1_power_to_settle: assert property (@(posedge clk) disable iff (rst)
    ($past(phase_q) == PH_POWER && phase_q != PH_POWER) |-> phase_q == PH_SETTLE);
  a_r1_settle_to_integ: assert property (@(posedge clk) disable iff (rst)
    ($past(phase_q) == PH_SETTLE && phase_q != PH_SETTLE) |-> phase_q == PH_INTEG);
  // R1: a window is left only after its final cycle
  a_r1_leave_on_last: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> $past(last_cyc));

endmodule

// File: rtl/sdseq_modulator.sv
module sdseq_modulator
  import sdseq_pkg::*;
#(
  parameter int DIV   = 125,
  parameter int RES_W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  phase_e       phase,
  input  logic         last_cyc,
  input  logic         cmp_async,
  output logic         fb,
  output logic         win_end,
  output logic [RES_W:0] count_next
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          cmp_s1, cmp_s2;
  logic [DW-1:0] div_q;
  logic          tick;
  logic          fb_q;
  logic          count_inc;
  logic [RES_W:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_s1 <= 1'b0;
      cmp_s2 <= 1'b0;
    end else begin
      cmp_s1 <= cmp_async;
      cmp_s2 <= cmp_s1;
    end
  end

  // sample-tick divider, realigned at every window boundary
  always_ff @(posedge clk) begin
    if (rst || phase == PH_POWER || last_cyc || div_q == DW'(DIV - 1))
      div_q <= '0;
    else
      div_q <= div_q + 1'b1;
  end

  assign tick = (phase != PH_POWER) && (div_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || phase == PH_POWER) fb_q <= 1'b0;
    else if (tick)                fb_q <= ~cmp_s2;
  end

  assign fb = fb_q & (phase != PH_POWER);

  assign count_inc  = (phase == PH_INTEG) && tick && cmp_s2;
  assign count_next = count_q + {{RES_W{1'b0}}, count_inc};
  assign win_end    = (phase == PH_INTEG) && last_cyc;

  always_ff @(posedge clk) begin
    if (rst || (phase == PH_SETTLE && last_cyc)) count_q <= '0;
    else if (count_inc)                          count_q <= count_next;
  end

  // R2: feedback is quiet while the sensor is powered
  a_r2_fb_quiet_in_power: assert property (@(posedge clk) disable iff (rst)
    phase == PH_POWER |-> !fb);
  // R3: the count starts every integrate window at zero
  a_r3_count_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_SETTLE && phase == PH_INTEG) |-> count_q == '0);
  // R4: one window never holds more ticks than 2**RES_W
  a_r4_count_cap: assert property (@(posedge clk) disable iff (rst)
    count_q <= (RES_W+1)'(2**RES_W));

endmodule

// File: rtl/sdseq_result.sv
module sdseq_result
  import sdseq_pkg::*;
#(
  parameter int RES_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic [RES_W:0]   count_next,
  output logic [RES_W-1:0] raw,
  output logic [6:0]       scaled,
  output logic             valid
);
  localparam int RAW_MAX = 2**RES_W - 1;

  logic [RES_W-1:0] sat_val;

  assign sat_val = (count_next > (RES_W+1)'(RAW_MAX)) ? RES_W'(RAW_MAX)
                                                       : count_next[RES_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      raw    <= '0;
      scaled <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= win_end;
      if (win_end) begin
        raw    <= sat_val;
        scaled <= scale_reading(16'(sat_val));
      end
    end
  end

  // R5: the strobe lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R5: results move only together with the strobe
  a_r5_raw_hold: assert property (@(posedge clk) disable iff (rst)
    (raw != $past(raw) || scaled != $past(scaled)) |-> valid);
  // R6: the scaled reading never passes the clamp
  a_r6_scaled_cap: assert property (@(posedge clk) disable iff (rst)
    scaled <= 7'(SC_LIMIT));

endmodule

// File: rtl/sensor_sd_sequencer.sv
module sensor_sd_sequencer
  import sdseq_pkg::*;
#(
  parameter int CYCLES_PER_US = 250,
  parameter int POWER_US      = 1536,
  parameter int SETTLE_US     = 256,
  parameter int INTEG_US      = 256,
  parameter int RES_W         = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sd_cmp,
  output logic             sensor_pwr_en,
  output logic             sd_fb,
  output logic [RES_W-1:0] raw_value,
  output logic [6:0]       scaled_value,
  output logic             value_valid
);
  localparam int POWER_CYC  = CYCLES_PER_US * POWER_US;
  localparam int SETTLE_CYC = CYCLES_PER_US * SETTLE_US;
  localparam int INTEG_CYC  = CYCLES_PER_US * INTEG_US;
  localparam int DIV        = INTEG_CYC / (2**RES_W);

  phase_e         phase;
  logic           last_cyc;
  logic           win_end;
  logic [RES_W:0] count_next;

  sdseq_timer #(
    .POWER_CYC (POWER_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .INTEG_CYC (INTEG_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .last_cyc(last_cyc)
  );

  sdseq_modulator #(
    .DIV  (DIV),
    .RES_W(RES_W)
  ) u_mod (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .last_cyc  (last_cyc),
    .cmp_async (sd_cmp),
    .fb        (sd_fb),
    .win_end   (win_end),
    .count_next(count_next)
  );

  sdseq_result #(
    .RES_W(RES_W)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .win_end   (win_end),
    .count_next(count_next),
    .raw       (raw_value),
    .scaled    (scaled_value),
    .valid     (value_valid)
  );

  assign sensor_pwr_en = (phase == PH_POWER);

  // R2: power and feedback are never both active at the pins
  a_r2_pins_exclusive: assert property (@(posedge clk) disable iff (rst)
    sensor_pwr_en |-> !sd_fb);
  // R5: a new result always opens a power window
  a_r5_valid_in_power: assert property (@(posedge clk) disable iff (rst)
    value_valid |-> sensor_pwr_en);

endmodule

// File: tb/sensor_sd_sequencer_tb.sv
module sensor_sd_sequencer_tb;
  localparam int CPU    = 2;
  localparam int P_US   = 96;
  localparam int S_US   = 64;
  localparam int I_US   = 512;
  localparam int RW     = 9;
  localparam int P_CYC  = CPU * P_US;
  localparam int S_CYC  = CPU * S_US;
  localparam int I_CYC  = CPU * I_US;
  localparam int F_CYC  = P_CYC + S_CYC + I_CYC;
  localparam int LOOP_TOL = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sd_cmp = 1'b0;
  logic          sensor_pwr_en, sd_fb, value_valid;
  logic [RW-1:0] raw_value;
  logic [6:0]    scaled_value;

  always #2 clk = ~clk;

  sensor_sd_sequencer #(
    .CYCLES_PER_US(CPU), .POWER_US(P_US), .SETTLE_US(S_US),
    .INTEG_US(I_US), .RES_W(RW)
  ) u_dut (
    .clk(clk), .rst(rst), .sd_cmp(sd_cmp),
    .sensor_pwr_en(sensor_pwr_en), .sd_fb(sd_fb),
    .raw_value(raw_value), .scaled_value(scaled_value),
    .value_valid(value_valid)
  );

  typedef struct {
    int    lo;
    int    hi;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  int   mode = 0;      // 0 low, 1 high, 2 high until mid-settle, 3 loop
  int   level = 0;
  int   acc = 0;
  int   frame_cyc = -1;
  int   pcnt = 0;
  int   fb_in_power = 0;
  bit   prev_valid = 0;
  bit   done = 0;
  logic [RW-1:0] last_raw = '0;
  logic [6:0]    last_scaled = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_scale(input int raw);
    int v;
    if (raw < 130) return 0;
    v = ((raw - 130) * 81) / 256;
    return (v > 100) ? 100 : v;
  endfunction

  // monitor, scoreboard and comparator model on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      frame_cyc = -1;
      pcnt = 0;
    end else begin
      if (value_valid) begin
        check(frame_cyc + 1 == F_CYC, "R5", "frame period", frame_cyc + 1, F_CYC);
        check(!prev_valid, "R5", "strobe width", 2, 1);
        if (q.size() == 0) begin
          check(0, "R5", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(raw_value) >= e.lo && int'(raw_value) <= e.hi, e.req,
                "raw", int'(raw_value), e.lo);
          check(int'(scaled_value) == ref_scale(int'(raw_value)), "R6",
                "scaled", int'(scaled_value), ref_scale(int'(raw_value)));
        end
        frame_cyc = 0;
        pcnt = 1;
        last_raw = raw_value;
        last_scaled = scaled_value;
      end else begin
        frame_cyc++;
        if (raw_value != last_raw || scaled_value != last_scaled)
          check(0, "R5", "result moved without strobe", int'(raw_value), int'(last_raw));
        if (sensor_pwr_en) pcnt++;
        else if (pcnt != 0) begin
          check(pcnt == P_CYC, "R1", "power window length", pcnt, P_CYC);
          check(frame_cyc == P_CYC, "R1", "power ends at frame offset", frame_cyc, P_CYC);
          pcnt = 0;
        end
      end
      if (sensor_pwr_en && sd_fb) fb_in_power++;
      if (frame_cyc == P_CYC + S_CYC - 1 && mode <= 1)
        check(sd_fb == (mode == 0), "R2", "feedback at settle end",
              int'(sd_fb), (mode == 0) ? 1 : 0);
    end
    prev_valid = value_valid;
    case (mode)
      0: sd_cmp = 1'b0;
      1: sd_cmp = 1'b1;
      2: sd_cmp = (frame_cyc >= 0) && (frame_cyc < P_CYC + S_CYC / 2);
      default: begin
        acc = acc + level - (sd_fb ? 0 : 512);
        if (acc > 8192) acc = 8192;
        if (acc < -8192) acc = -8192;
        sd_cmp = (acc > 0);
      end
    endcase
  end

  task automatic run_frame(input int m, input int lv, input int lo,
                           input int hi, input string req);
    exp_t e;
    mode = m;
    level = lv;
    e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
    @(posedge value_valid);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state
    check(sensor_pwr_en == 1'b1, "R7", "power in reset", int'(sensor_pwr_en), 1);
    check(sd_fb == 1'b0, "R7", "fb in reset", int'(sd_fb), 0);
    check(value_valid == 1'b0, "R7", "valid in reset", int'(value_valid), 0);
    check(raw_value == '0, "R7", "raw in reset", int'(raw_value), 0);
    check(scaled_value == '0, "R7", "scaled in reset", int'(scaled_value), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(sensor_pwr_en == 1'b1 && value_valid == 1'b0, "R7", "state after release",
          int'(sensor_pwr_en), 1);
    run_frame(0, 0, 0, 0, "R4");      // all zeros
    run_frame(1, 0, 511, 511, "R4");  // all ones saturate
    run_frame(2, 0, 0, 0, "R3");      // ones only before integrate
    run_frame(3, 300, 300 - LOOP_TOL, 300 + LOOP_TOL, "R8");
    run_frame(3, 100, 100 - LOOP_TOL, 100 + LOOP_TOL, "R8");
    run_frame(3, 447, 447 - LOOP_TOL, 447 + LOOP_TOL, "R8");
    run_frame(3, 200, 200 - LOOP_TOL, 200 + LOOP_TOL, "R8");
    run_frame(3, 140, 140 - LOOP_TOL, 140 + LOOP_TOL, "R8");
    run_frame(1, 0, 511, 511, "R4");
    run_frame(2, 0, 0, 0, "R3");
    run_frame(0, 0, 0, 0, "R4");
    check(fb_in_power == 0, "R2", "fb high during power", fb_in_power, 0);
    check(q.size() == 0, "R5", "results outstanding", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 60000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule